// File: doc/BRIEF.md
# Range-Matched Translation Buffer

This block is a small fully associative address translation buffer. Each slot holds a page-aligned virtual range (a first and a last address), a physical page number, a packed set of protection fields and a valid flag. A lookup port compares a virtual address against every slot at once. It returns either a hit with the fields of the matching slot, or a miss class that depends on whether the access is an instruction fetch.

Software-style maintenance arrives on one command port. A slot is filled in two steps: an address command reserves a slot and loads its range and physical page, and a protection command then loads the protection fields and makes the slot valid. In between, the slot holds its range but stays invalid. Two purge commands remove either the slot covering one address or every slot. Permission checking and fault reporting belong to the consumer of the lookup outputs.

Lookup is purely combinational from registered slot state and has no handshake. The command port is a one-cycle `cmd_valid` strobe with no ready signal and no back-pressure: every command offered is taken at the next rising clock edge. Nothing is ever stalled.

Top module: `rtlb_range_tlb`

## Requirements
- R1: A slot covers an address when first <= address <= last, both bounds inclusive. When several slots cover a lookup address, the lowest-indexed one alone decides the result, even if it is invalid (the lookup is then a miss).
- R2: Lookup is combinational in the same cycle. Exactly one of `lk_hit`, `lk_miss_instr`, `lk_miss_data` is high. A hit needs a valid deciding slot. A miss raises `lk_miss_instr` when `lk_exec`=1 and `lk_miss_data` otherwise. On a hit, `lk_idx` and the field outputs come from that slot. On a miss, the field outputs are zero.
- R3: Command op 0 (set-address) clears every slot that covers `cmd_addr`. Its destination is the lowest-indexed slot that is either invalid or covers `cmd_addr`.
- R4: If no slot qualifies under R3, the destination is the slot at a rotating pointer, which then advances by one and wraps from ENTRIES-1 to 0. The pointer does not move in any other case and is 0 after reset.
- R5: Set-address loads first = `cmd_addr` with its low 12 bits cleared, last = first + 0xFFF, and physical page = `cmd_word[24:5]`; all other word bits are ignored. The slot is left invalid, so a lookup that it decides misses.
- R6: Command op 1 (set-protection) writes the lowest-indexed slot covering `cmd_addr` and marks it valid. The word is unpacked as access id [18:1], U [19], PL2 [21:20], PL1 [23:22], kind [26:24], B [27], D [28], T [29]; bits 0, 30 and 31 are ignored.
- R7: Set-protection with no covering slot changes no slot. `prot_err` is then high for exactly the one cycle after that command's edge; otherwise it is low.
- R8: Command op 2 (drop-one) clears the lowest-indexed slot covering `cmd_addr` only if that slot is valid. A pending invalid slot survives. A cleared slot has first = last = 0, all fields zero and is invalid.
- R9: Command op 3 (drop-all) clears every slot at the next edge.
- R10: A synchronous reset clears every slot, zeroes the pointer and `prot_err`. Every command acts on the rising edge at which `cmd_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | AW | Lookup virtual address |
| lk_exec | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Deciding slot is valid |
| lk_miss_instr | output | 1 | Miss on an instruction fetch |
| lk_miss_data | output | 1 | Miss on a data access |
| lk_idx | output | $clog2(ENTRIES) | Index of the hitting slot |
| lk_ppn | output | 20 | Physical page number |
| lk_acc_id | output | 18 | Access identifier |
| lk_u | output | 1 | U flag |
| lk_pl2 | output | 2 | Second privilege bound |
| lk_pl1 | output | 2 | First privilege bound |
| lk_kind | output | 3 | Access-rights kind |
| lk_b | output | 1 | B flag |
| lk_d | output | 1 | D flag |
| lk_t | output | 1 | T flag |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set-address, 1 set-protection, 2 drop-one, 3 drop-all |
| cmd_addr | input | AW | Command virtual address |
| cmd_word | input | 32 | Command data word |
| prot_err | output | 1 | Set-protection found no covering slot |

## Verification
The bench builds the block with ENTRIES=4 and the default 32-bit addresses and 4 KiB pages. With only four slots, a handful of commands fills the buffer. That reaches the rotating-pointer eviction, its wrap from slot 3 back to slot 0, and the case where a slot freed by drop-one is preferred over the pointer. Four slots also make it easy to build the overlap in which a cleared slot spanning address 0 shadows a valid page-0 slot at a higher index.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;

  localparam int PPN_LSB = 5;
  localparam int PPN_W   = 20;

  typedef enum logic [1:0] {
    CMD_SET_ADDR = 2'd0,
    CMD_SET_PROT = 2'd1,
    CMD_DROP_ONE = 2'd2,
    CMD_DROP_ALL = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [17:0] acc_id;
    logic        u;
    logic [1:0]  pl2;
    logic [1:0]  pl1;
    logic [2:0]  kind;
    logic        b;
    logic        d;
    logic        t;
  } prot_t;

  function automatic prot_t unpack_prot(input logic [29:1] w);
    prot_t p;
    p.acc_id = w[18:1];
    p.u      = w[19];
    p.pl2    = w[21:20];
    p.pl1    = w[23:22];
    p.kind   = w[26:24];
    p.b      = w[27];
    p.d      = w[28];
    p.t      = w[29];
    return p;
  endfunction

endpackage

// File: rtl/rtlb_first.sv
module rtlb_first #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rtlb_slot.sv
module rtlb_slot #(
  parameter int AW  = 32,
  parameter int PGB = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     load_addr,
  input  logic                     load_prot,
  input  logic [AW-1:0]            new_first,
  input  logic [rtlb_pkg::PPN_W-1:0] new_ppn,
  input  rtlb_pkg::prot_t          new_prot,
  input  logic [AW-1:0]            lk_addr,
  input  logic [AW-1:0]            cm_addr,
  output logic                     lk_cov,
  output logic                     cm_cov,
  output logic                     valid,
  output logic [rtlb_pkg::PPN_W-1:0] ppn,
  output rtlb_pkg::prot_t          prot
);
  localparam logic [AW-1:0] PG_SPAN = AW'((64'd1 << PGB) - 64'd1);

  logic [AW-1:0] first_q, last_q;

  assign lk_cov = (first_q <= lk_addr) && (lk_addr <= last_q);
  assign cm_cov = (first_q <= cm_addr) && (cm_addr <= last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      ppn     <= '0;
      prot    <= '0;
      valid   <= 1'b0;
    end else if (load_addr) begin
      first_q <= new_first;
      last_q  <= new_first + PG_SPAN;
      ppn     <= new_ppn;
      prot    <= '0;
      valid   <= 1'b0;
    end else if (clr) begin
      first_q <= '0;
      last_q  <= '0;
      ppn     <= '0;
      prot    <= '0;
      valid   <= 1'b0;
    end else if (load_prot) begin
      prot  <= new_prot;
      valid <= 1'b1;
    end
  end

  p_load_pending_r5: assert property (@(posedge clk) disable iff (rst)
    load_addr |=> (!valid && (last_q - first_q == PG_SPAN)));

  p_prot_validates_r6: assert property (@(posedge clk) disable iff (rst)
    (load_prot && !load_addr && !clr) |=> valid);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !load_addr) |=> (!valid && last_q == '0));
endmodule

// File: rtl/rtlb_victim.sv
module rtlb_victim #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [N-1:0]  free_vec,
  output logic [IW-1:0] dest
);
  logic          have_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_q;
  logic          bump;

  rtlb_first #(.N(N)) u_free (
    .vec   (free_vec),
    .found (have_free),
    .idx   (free_idx)
  );

  assign dest = have_free ? free_idx : rr_q;
  assign bump = take && !have_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (bump) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_rr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (bump && rr_q == IW'(N - 1)) |=> (rr_q == '0));

  p_rr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (bump && rr_q != IW'(N - 1)) |=> (rr_q == $past(rr_q) + 1'b1));

  p_rr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(rr_q));

  p_free_first_r3: assert property (@(posedge clk) disable iff (rst)
    (take && have_free) |-> free_vec[dest]);
endmodule

// File: rtl/rtlb_range_tlb.sv
module rtlb_range_tlb #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int PGB     = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [AW-1:0]                lk_addr,
  input  logic                         lk_exec,
  output logic                         lk_hit,
  output logic                         lk_miss_instr,
  output logic                         lk_miss_data,
  output logic [$clog2(ENTRIES)-1:0]   lk_idx,
  output logic [19:0]                  lk_ppn,
  output logic [17:0]                  lk_acc_id,
  output logic                         lk_u,
  output logic [1:0]                   lk_pl2,
  output logic [1:0]                   lk_pl1,
  output logic [2:0]                   lk_kind,
  output logic                         lk_b,
  output logic                         lk_d,
  output logic                         lk_t,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [AW-1:0]                cmd_addr,
  input  logic [31:0]                  cmd_word,
  output logic                         prot_err
);
  import rtlb_pkg::*;

  localparam int IW = $clog2(ENTRIES);
  localparam logic [AW-1:0] PG_CUT = ~AW'((64'd1 << PGB) - 64'd1);

  logic [ENTRIES-1:0] lk_cov, cm_cov, vld;
  logic [ENTRIES-1:0] s_clr, s_load_addr, s_load_prot;
  logic [PPN_W-1:0]   ppn_a  [ENTRIES];
  prot_t              prot_a [ENTRIES];

  logic is_addr, is_prot, is_one, is_all;
  assign is_addr = cmd_valid && (cmd_op == CMD_SET_ADDR);
  assign is_prot = cmd_valid && (cmd_op == CMD_SET_PROT);
  assign is_one  = cmd_valid && (cmd_op == CMD_DROP_ONE);
  assign is_all  = cmd_valid && (cmd_op == CMD_DROP_ALL);

  logic [AW-1:0]    new_first;
  logic [PPN_W-1:0] new_ppn;
  prot_t            new_prot;
  logic [2:0]       unused_word_bits;

  assign new_first        = cmd_addr & PG_CUT;
  assign new_ppn          = cmd_word[PPN_LSB +: PPN_W];
  assign new_prot         = unpack_prot(cmd_word[29:1]);
  assign unused_word_bits = {cmd_word[31:30], cmd_word[0]};

  // command-side match
  logic          cm_found;
  logic [IW-1:0] cm_idx;
  rtlb_first #(.N(ENTRIES)) u_cm_first (
    .vec   (cm_cov),
    .found (cm_found),
    .idx   (cm_idx)
  );

  // destination for set-address
  logic [IW-1:0] dest;
  rtlb_victim #(.N(ENTRIES)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .take     (is_addr),
    .free_vec (~vld | cm_cov),
    .dest     (dest)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign s_load_addr[g] = is_addr && (dest == IW'(g));
    assign s_load_prot[g] = is_prot && cm_found && (cm_idx == IW'(g));
    assign s_clr[g] = is_all
                    || (is_one && cm_found && (cm_idx == IW'(g)) && vld[g])
                    || (is_addr && cm_cov[g] && (dest != IW'(g)));

    rtlb_slot #(.AW(AW), .PGB(PGB)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .clr       (s_clr[g]),
      .load_addr (s_load_addr[g]),
      .load_prot (s_load_prot[g]),
      .new_first (new_first),
      .new_ppn   (new_ppn),
      .new_prot  (new_prot),
      .lk_addr   (lk_addr),
      .cm_addr   (cmd_addr),
      .lk_cov    (lk_cov[g]),
      .cm_cov    (cm_cov[g]),
      .valid     (vld[g]),
      .ppn       (ppn_a[g]),
      .prot      (prot_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prot_err <= 1'b0;
    else     prot_err <= is_prot && !cm_found;
  end

  // lookup side
  logic          lk_found;
  logic [IW-1:0] lk_sel;
  rtlb_first #(.N(ENTRIES)) u_lk_first (
    .vec   (lk_cov),
    .found (lk_found),
    .idx   (lk_sel)
  );

  prot_t sel_prot;
  always_comb begin
    lk_hit        = lk_found && vld[lk_sel];
    lk_miss_instr = !lk_hit && lk_exec;
    lk_miss_data  = !lk_hit && !lk_exec;
    lk_idx        = lk_hit ? lk_sel : '0;
    lk_ppn        = lk_hit ? ppn_a[lk_sel] : '0;
    sel_prot      = lk_hit ? prot_a[lk_sel] : '0;
    lk_acc_id     = sel_prot.acc_id;
    lk_u          = sel_prot.u;
    lk_pl2        = sel_prot.pl2;
    lk_pl1        = sel_prot.pl1;
    lk_kind       = sel_prot.kind;
    lk_b          = sel_prot.b;
    lk_d          = sel_prot.d;
    lk_t          = sel_prot.t;
  end

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({lk_hit, lk_miss_instr, lk_miss_data}) == 1);

  p_hit_covers_r1: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_cov[lk_idx] && vld[lk_idx]));

  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    prot_err |-> $past(is_prot));

  p_err_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (is_prot && !cm_found) |=> ($stable(vld) && prot_err));

  p_drop_all_r9: assert property (@(posedge clk) disable iff (rst)
    is_all |=> (vld == '0));
endmodule

// File: tb/sim_rtlb_range_tlb.sv
module sim_rtlb_range_tlb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_exec = 1'b0;
  logic        lk_hit, lk_miss_instr, lk_miss_data;
  logic [1:0]  lk_idx;
  logic [19:0] lk_ppn;
  logic [17:0] lk_acc_id;
  logic        lk_u, lk_b, lk_d, lk_t;
  logic [1:0]  lk_pl2, lk_pl1;
  logic [2:0]  lk_kind;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_word = '0;
  logic        prot_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtlb_range_tlb #(.ENTRIES(N)) u0 (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_exec(lk_exec),
    .lk_hit(lk_hit), .lk_miss_instr(lk_miss_instr), .lk_miss_data(lk_miss_data),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_acc_id(lk_acc_id), .lk_u(lk_u),
    .lk_pl2(lk_pl2), .lk_pl1(lk_pl1), .lk_kind(lk_kind), .lk_b(lk_b),
    .lk_d(lk_d), .lk_t(lk_t), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_word(cmd_word), .prot_err(prot_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkp(input logic [17:0] acc, input logic u, input logic [1:0] pl2,
                                      input logic [1:0] pl1, input logic [2:0] kind,
                                      input logic b, input logic d, input logic t);
    return {2'b11, t, d, b, kind, pl1, pl2, u, acc, 1'b1};
  endfunction

  function automatic logic [31:0] mka(input logic [19:0] ppn);
    return ({12'd0, ppn} << 5) | 32'hFE00_001F;
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] w);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] a, input logic [19:0] ppn, input logic [31:0] pw);
    do_cmd(2'd0, a, mka(ppn));
    do_cmd(2'd1, a, pw);
  endtask

  task automatic exp_hit(input logic [31:0] a, input logic [1:0] idx, input logic [19:0] ppn,
                         input logic [31:0] pw, input string req);
    logic [28:0] got;
    lk_addr = a; lk_exec = 1'b0; #1;
    got = {lk_t, lk_d, lk_b, lk_kind, lk_pl1, lk_pl2, lk_u, lk_acc_id};
    chk(lk_hit && !lk_miss_instr && !lk_miss_data, {req, " hit"}, {lk_hit, lk_miss_instr, lk_miss_data}, 3'b100);
    chk(lk_idx == idx, {req, " index"}, lk_idx, idx);
    chk(lk_ppn == ppn, {req, " ppn"}, lk_ppn, ppn);
    chk(got == pw[29:1], {req, " fields"}, got, pw[29:1]);
  endtask

  task automatic exp_miss(input logic [31:0] a, input logic ex, input string req);
    lk_addr = a; lk_exec = ex; #1;
    chk({lk_hit, lk_miss_instr, lk_miss_data} == {1'b0, ex, !ex}, {req, " miss class"},
        {lk_hit, lk_miss_instr, lk_miss_data}, {1'b0, ex, !ex});
    chk(lk_ppn == 0 && lk_acc_id == 0 && lk_kind == 0, {req, " zero fields"}, {lk_ppn, lk_acc_id}, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  localparam logic [31:0] PW1 = mkp(18'h2A5A5, 1'b1, 2'd2, 2'd3, 3'd5, 1'b1, 1'b0, 1'b1);
  localparam logic [31:0] PW2 = mkp(18'h01234, 1'b0, 2'd1, 2'd0, 3'd2, 1'b0, 1'b1, 1'b0);

  task automatic t_reset();
    do_reset();
    chk(prot_err == 1'b0, "R10 err after reset", prot_err, 0);
    exp_miss(32'h0000_1234, 1'b0, "R10 data");
    exp_miss(32'h0000_1234, 1'b1, "R2 instr");
    exp_miss(32'h0000_0000, 1'b1, "R10 cleared slot");
  endtask

  task automatic t_basic();
    do_reset();
    do_cmd(2'd0, 32'h0001_2345, mka(20'hABCDE));
    exp_miss(32'h0001_2345, 1'b0, "R5 pending invalid");
    do_cmd(2'd1, 32'h0001_2FFF, PW1);
    chk(prot_err == 1'b0, "R6 no err", prot_err, 0);
    exp_hit(32'h0001_2000, 2'd0, 20'hABCDE, PW1, "R5 first bound");
    exp_hit(32'h0001_2FFF, 2'd0, 20'hABCDE, PW1, "R1 last bound");
    exp_miss(32'h0001_1FFF, 1'b0, "R1 below");
    exp_miss(32'h0001_3000, 1'b1, "R1 above");
  endtask

  task automatic t_prot_err();
    do_cmd(2'd1, 32'h9999_0000, PW2);
    chk(prot_err == 1'b1, "R7 err strobe", prot_err, 1);
    @(negedge clk);
    chk(prot_err == 1'b0, "R7 err one cycle", prot_err, 0);
    exp_hit(32'h0001_2345, 2'd0, 20'hABCDE, PW1, "R7 unchanged");
  endtask

  task automatic t_round_robin();
    do_reset();
    fill(32'h0000_1000, 20'h00001, PW1);
    fill(32'h0000_2000, 20'h00002, PW1);
    fill(32'h0000_3000, 20'h00003, PW1);
    fill(32'h0000_4000, 20'h00004, PW1);
    exp_hit(32'h0000_4800, 2'd3, 20'h00004, PW1, "R3 lowest free");
    fill(32'h0000_5000, 20'h00005, PW2);
    exp_hit(32'h0000_5000, 2'd0, 20'h00005, PW2, "R4 victim 0");
    exp_miss(32'h0000_1000, 1'b0, "R4 evicted");
    fill(32'h0000_6000, 20'h00006, PW2);
    exp_hit(32'h0000_6000, 2'd1, 20'h00006, PW2, "R4 victim 1");
    fill(32'h0000_7000, 20'h00007, PW2);
    fill(32'h0000_8000, 20'h00008, PW2);
    exp_hit(32'h0000_8000, 2'd3, 20'h00008, PW2, "R4 victim 3");
    fill(32'h0000_9000, 20'h00009, PW1);
    exp_hit(32'h0000_9000, 2'd0, 20'h00009, PW1, "R4 wrap to 0");
  endtask

  task automatic t_skip_empty();
    do_cmd(2'd2, 32'h0000_7ABC, 32'h0);
    exp_miss(32'h0000_7000, 1'b0, "R8 drop valid");
    fill(32'h0000_A000, 20'h0000A, PW1);
    exp_hit(32'h0000_A000, 2'd2, 20'h0000A, PW1, "R3 reuse dropped slot");
    fill(32'h0000_B000, 20'h0000B, PW1);
    exp_hit(32'h0000_B000, 2'd1, 20'h0000B, PW1, "R4 pointer unmoved by skip");
  endtask

  task automatic t_recover();
    do_cmd(2'd0, 32'h0000_B800, mka(20'h7777B));
    exp_miss(32'h0000_B000, 1'b1, "R3 covering purged");
    do_cmd(2'd1, 32'h0000_B000, PW2);
    exp_hit(32'h0000_BFFF, 2'd1, 20'h7777B, PW2, "R3 same slot reused");
    do_cmd(2'd0, 32'h0000_D000, mka(20'h0000D));
    do_cmd(2'd2, 32'h0000_D000, 32'h0);
    do_cmd(2'd1, 32'h0000_D000, PW1);
    chk(prot_err == 1'b0, "R8 pending survives drop", prot_err, 0);
    exp_hit(32'h0000_D000, 2'd2, 20'h0000D, PW1, "R8 pending kept");
  endtask

  task automatic t_drop_all();
    do_cmd(2'd3, 32'h0, 32'h0);
    exp_miss(32'h0000_D000, 1'b0, "R9 gone D");
    exp_miss(32'h0000_9000, 1'b1, "R9 gone 9");
    fill(32'h0000_E000, 20'h0000E, PW2);
    exp_hit(32'h0000_E000, 2'd0, 20'h0000E, PW2, "R9 slot 0 free");
  endtask

  task automatic t_priority();
    do_reset();
    fill(32'h0000_5000, 20'h00005, PW1);
    fill(32'h0000_0000, 20'h00000, PW2);
    exp_hit(32'h0000_0000, 2'd1, 20'h00000, PW2, "R1 page0 in slot1");
    do_cmd(2'd2, 32'h0000_5000, 32'h0);
    exp_miss(32'h0000_0000, 1'b0, "R1 lowest cleared slot shadows");
    exp_hit(32'h0000_0004, 2'd1, 20'h00000, PW2, "R1 past shadow");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prot_err();
    t_round_robin();
    t_skip_empty();
    t_recover();
    t_drop_all();
    t_priority();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule